// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital timing and control engine of a successive-approximation converter. Software programs it through a small byte-wide register port. A start request can come from a software write or from an external PWM trigger pulse. The block then derives a slow converter clock from the system clock. It runs a channel-switch phase, a hold phase and a sample phase, each with a programmable length. After that it resolves the result one bit per converter clock, most significant bit first.

During the bit cycles it presents the current trial code to the DAC, pulses a comparator strobe once per bit and takes the comparator decision as a plain digital input. When the last bit is resolved, the block stores the result and raises a completion flag. The result reads back as a high byte and a low byte, aligned either left or right. A channel code of all ones selects the internal reference instead of an external input.

Top module: `sar_adc_seq`

## Requirements
- R1: After a synchronous reset every readable register reads 0, and `ch_sel`, `ref_sel`, `cmp_strobe` and `sar_code` are 0.
- R2: A start request is accepted only when power is enabled and no conversion is running. A software start with power off is ignored, and so is a start of either kind during a conversion. Power is control bit 7 and start is control bit 6. A control write that sets both bits starts a conversion.
- R3: The converter clock period is 2*(S+1) system clocks, where S is config bits 3:0. A conversion lasts (W+1)+(H+1)+(M+1)+N converter clocks, where W is timing bit 7, H is timing bits 6:5, M is timing bits 4:0 and N is the resolution (12). The flag is set exactly that many system clocks times the period after the edge that accepts the start.
- R4: `cmp_strobe` pulses exactly N times per conversion, one system clock wide, once per converter clock of the bit phase only.
- R5: Bits are resolved MSB first. Each trial bit is set, then kept when `cmp_in` is 1 at the end of its converter clock and cleared otherwise. With a comparator that reports trial <= V, the result equals V.
- R6: Config bit 5 = 1 reads the result right-aligned: high byte (address 3) = {4'b0, r[11:8]} and low byte (address 4) = r[7:0]. Config bit 5 = 0 reads it left-aligned: high byte = r[11:4] and low byte = {r[3:0], 4'b0}.
- R7: The completion flag is control bit 5. Writing 0 to it clears it and writing 1 has no effect. A completion in the same cycle as a clearing write leaves the flag set.
- R8: Control bit 6 reads 1 while a conversion runs. It returns to 0 in the same cycle that the flag sets and the result updates.
- R9: With control bit 4 = 1, a one-cycle `pwm_trig` pulse starts a conversion. With bit 4 = 0 the pulse is ignored.
- R10: `ch_sel` holds the channel (control bits 3:0) captured when the start is accepted. It does not follow later writes. `ref_sel` is 1 exactly when that channel is 4'hF.
- R11: Register writes during a conversion do not change its timing. These are the config, the timing register and the channel.
- R12: Writing control bit 7 = 0 during a conversion aborts it. The flag is not set, no further strobes occur and bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address: 0 control, 1 config, 2 timing, 3 result high, 4 result low |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| pwm_trig | input | 1 | External conversion trigger pulse |
| cmp_in | input | 1 | Comparator decision: 1 means input at or above trial code |
| ch_sel | output | 4 | Channel select for the analog multiplexer |
| ref_sel | output | 1 | Internal reference selected |
| sar_code | output | RES_BITS | Trial code to the SAR DAC |
| cmp_strobe | output | 1 | Per-bit comparator strobe |

## Verification
Two events can fall in the same clock edge: hardware completion setting the flag, and a software write clearing it. The bench computes the exact completion edge from the programmed speed and phase lengths. It issues a control write with bit 5 = 0 in the cycle just before that edge, on top of a flag left set by the previous conversion. It then judges that the flag reads 1, that the start bit reads 0 and that the new result is visible. This shows that the set took precedence and that all three updated together.

// File: rtl/sar_adc_pkg.sv
// Shared definitions for the SAR ADC sequencer: phase encoding, register
// addresses and control-register bit positions.
package sar_adc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SWITCH,
        PH_HOLD,
        PH_SAMPLE,
        PH_CONV
    } phase_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CFG  = 3'd1;
    localparam logic [2:0] A_TIM  = 3'd2;
    localparam logic [2:0] A_RHI  = 3'd3;
    localparam logic [2:0] A_RLO  = 3'd4;

    localparam int CTRL_PWR  = 7;
    localparam int CTRL_GO   = 6;
    localparam int CTRL_FLAG = 5;
    localparam int CTRL_TRIG = 4;
    localparam int CFG_ALIGN = 5;
    localparam int TIM_SW    = 7;

endpackage

// File: rtl/sar_adc_clkdiv.sv
// Converter-clock generator. While run is high it emits a one-cycle tick
// every 2*(speed+1) system clocks. The first tick comes that many clocks
// after run rises. The speed value is captured on load, so software may
// rewrite it mid-conversion. Assumes load coincides with the rise of run.
module sar_adc_clkdiv #(
    parameter int SPD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    output logic             tick
);
    localparam int CNT_W = SPD_W + 1;

    logic [SPD_W-1:0] spd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = {spd_q, 1'b1};
    assign tick  = run && (cnt_q == limit);

    // Capture the prescale setting at conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n)    spd_q <= '0;
        else if (load) spd_q <= speed;
    end

    // Free count while running, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sar_adc_phase_seq.sv
// Phase sequencer. It walks switch, hold, sample and bit phases, advancing
// only on converter-clock ticks. Phase lengths are latched at go. It
// reports the bit strobe, the index of the bit being decided and a done
// pulse on the final bit. Abort returns it to idle at once. Assumes
// HLD_W <= SMP_W.
module sar_adc_phase_seq
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int HLD_W    = 2,
    parameter int SMP_W    = 5,
    localparam int IDX_W   = $clog2(RES_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic             tick,
    input  logic             sw_long,
    input  logic [HLD_W-1:0] hold_len,
    input  logic [SMP_W-1:0] samp_len,
    output logic             busy,
    output logic             enter_conv,
    output logic             bit_strobe,
    output logic [IDX_W-1:0] bit_idx,
    output logic             done
);
    localparam int CNT_W = (SMP_W > IDX_W) ? SMP_W : IDX_W;

    phase_e           phase_q;
    phase_e           phase_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             sw_q;
    logic [HLD_W-1:0] hold_q;
    logic [SMP_W-1:0] samp_q;
    logic             phase_end;

    // Latch the phase lengths when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q   <= 1'b0;
            hold_q <= '0;
            samp_q <= '0;
        end else if (go) begin
            sw_q   <= sw_long;
            hold_q <= hold_len;
            samp_q <= samp_len;
        end
    end

    // Final count value of the current phase.
    always_comb begin
        case (phase_q)
            PH_SWITCH: last_cnt = CNT_W'(sw_q);
            PH_HOLD:   last_cnt = CNT_W'(hold_q);
            PH_SAMPLE: last_cnt = CNT_W'(samp_q);
            PH_CONV:   last_cnt = CNT_W'(RES_BITS - 1);
            default:   last_cnt = '0;
        endcase
    end

    // Successor phase in the fixed order.
    always_comb begin
        case (phase_q)
            PH_SWITCH: phase_nxt = PH_HOLD;
            PH_HOLD:   phase_nxt = PH_SAMPLE;
            PH_SAMPLE: phase_nxt = PH_CONV;
            default:   phase_nxt = PH_IDLE;
        endcase
    end

    assign phase_end  = tick && (cnt_q == last_cnt);
    assign busy       = (phase_q != PH_IDLE);
    assign enter_conv = phase_end && (phase_q == PH_SAMPLE) && !abort;
    assign bit_strobe = tick && (phase_q == PH_CONV) && !abort;
    assign done       = bit_strobe && (cnt_q == CNT_W'(RES_BITS - 1));
    assign bit_idx    = IDX_W'(RES_BITS - 1) - cnt_q[IDX_W-1:0];

    // Phase and in-phase counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (go) begin
            phase_q <= PH_SWITCH;
            cnt_q   <= '0;
        end else if (phase_end) begin
            phase_q <= phase_nxt;
            cnt_q   <= '0;
        end else if (tick) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sar_adc_sar.sv
// Successive-approximation register. It clears on start and loads the MSB
// trial on entry to the bit phase. On each strobe it writes the comparator
// decision into the bit under test and sets the next lower trial bit. On
// done it copies the final code into the result register.
module sar_adc_sar #(
    parameter int RES_BITS = 12,
    localparam int IDX_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load_msb,
    input  logic                strobe,
    input  logic                done,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                cmp,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] result
);
    logic [RES_BITS-1:0] code_nxt;

    // Decide the bit under test and raise the next trial bit.
    always_comb begin
        code_nxt = code;
        for (int i = 0; i < RES_BITS; i++) begin
            if (IDX_W'(i) == bit_idx) code_nxt[i] = cmp;
        end
        for (int i = 0; i < RES_BITS - 1; i++) begin
            if (IDX_W'(i + 1) == bit_idx) code_nxt[i] = 1'b1;
        end
    end

    // Trial code register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) code <= '0;
        else if (load_msb)   code <= {1'b1, {(RES_BITS-1){1'b0}}};
        else if (strobe)     code <= code_nxt;
    end

    // Result register, written on the final bit decision.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (done) result <= code_nxt;
    end
endmodule

// File: rtl/sar_adc_regs.sv
// Register file and start arbitration. It holds the control, config and
// timing bytes and the completion flag. It decides when a software or
// trigger start is accepted and when a write aborts a running conversion.
// It latches the channel for the multiplexer and aligns the result on
// read. Assumes RES_BITS <= 16.
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [2:0]          addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic                pwm_trig,
    input  logic                busy,
    input  logic                done,
    input  logic [RES_BITS-1:0] result,
    output logic                go,
    output logic                abort,
    output logic                pwr_on,
    output logic                done_flag,
    output logic [3:0]          ch_lat,
    output logic [3:0]          speed,
    output logic                sw_long,
    output logic [1:0]          hold_len,
    output logic [4:0]          samp_len
);
    localparam int PAD = 16 - RES_BITS;

    logic        trig_en_q;
    logic [3:0]  chan_q;
    logic        align_q;
    logic [7:0]  tim_q;
    logic        ctrl_wr;
    logic        pwr_eff;
    logic [3:0]  chan_eff;
    logic [15:0] res_word;

    assign ctrl_wr  = wr && (addr == A_CTRL);
    assign pwr_eff  = ctrl_wr ? wdata[CTRL_PWR] : pwr_on;
    assign chan_eff = ctrl_wr ? wdata[3:0] : chan_q;
    assign go       = pwr_eff && !busy &&
                      ((ctrl_wr && wdata[CTRL_GO]) || (pwm_trig && trig_en_q));
    assign abort    = busy && ctrl_wr && !wdata[CTRL_PWR];

    assign sw_long  = tim_q[TIM_SW];
    assign hold_len = tim_q[6:5];
    assign samp_len = tim_q[4:0];

    // Control byte: power, trigger enable and channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_on    <= 1'b0;
            trig_en_q <= 1'b0;
            chan_q    <= '0;
        end else if (ctrl_wr) begin
            pwr_on    <= wdata[CTRL_PWR];
            trig_en_q <= wdata[CTRL_TRIG];
            chan_q    <= wdata[3:0];
        end
    end

    // Completion flag: a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                           done_flag <= 1'b0;
        else if (done)                        done_flag <= 1'b1;
        else if (ctrl_wr && !wdata[CTRL_FLAG]) done_flag <= 1'b0;
    end

    // Channel presented to the multiplexer, frozen at start.
    always_ff @(posedge clk) begin
        if (!rst_n)  ch_lat <= '0;
        else if (go) ch_lat <= chan_eff;
    end

    // Config byte: alignment and prescale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_q <= 1'b0;
            speed   <= '0;
        end else if (wr && addr == A_CFG) begin
            align_q <= wdata[CFG_ALIGN];
            speed   <= wdata[3:0];
        end
    end

    // Timing byte: switch, hold and sample lengths.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tim_q <= '0;
        else if (wr && addr == A_TIM)   tim_q <= wdata;
    end

    assign res_word = align_q ? 16'(result) : (16'(result) << PAD);

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {pwr_on, busy, done_flag, trig_en_q, chan_q};
            A_CFG:   rdata = {2'b00, align_q, 1'b0, speed};
            A_TIM:   rdata = tim_q;
            A_RHI:   rdata = res_word[15:8];
            A_RLO:   rdata = res_word[7:0];
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/sar_adc_seq.sv
// Top level of the SAR ADC sequencer. It wires the register file, the
// converter-clock divider, the phase sequencer and the SAR register
// together. The comparator is a synchronous digital input, sampled on the
// tick that ends each bit. REF_CODE is the channel code of the internal
// reference.
module sar_adc_seq #(
    parameter int          RES_BITS = 12,
    parameter logic [3:0]  REF_CODE = 4'hF,
    localparam int         IDX_W    = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                pwm_trig,
    input  logic                cmp_in,
    output logic [3:0]          ch_sel,
    output logic                ref_sel,
    output logic [RES_BITS-1:0] sar_code,
    output logic                cmp_strobe
);
    logic                go;
    logic                abort;
    logic                busy;
    logic                pwr_on;
    logic                done_flag;
    logic                conv_done;
    logic                tick;
    logic                enter_conv;
    logic [IDX_W-1:0]    bit_idx;
    logic [3:0]          speed;
    logic                sw_long;
    logic [1:0]          hold_len;
    logic [4:0]          samp_len;
    logic [RES_BITS-1:0] result;

    sar_adc_regs #(.RES_BITS(RES_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .pwm_trig  (pwm_trig),
        .busy      (busy),
        .done      (conv_done),
        .result    (result),
        .go        (go),
        .abort     (abort),
        .pwr_on    (pwr_on),
        .done_flag (done_flag),
        .ch_lat    (ch_sel),
        .speed     (speed),
        .sw_long   (sw_long),
        .hold_len  (hold_len),
        .samp_len  (samp_len)
    );

    sar_adc_clkdiv #(.SPD_W(4)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .run   (busy),
        .speed (speed),
        .tick  (tick)
    );

    sar_adc_phase_seq #(.RES_BITS(RES_BITS), .HLD_W(2), .SMP_W(5)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .abort      (abort),
        .tick       (tick),
        .sw_long    (sw_long),
        .hold_len   (hold_len),
        .samp_len   (samp_len),
        .busy       (busy),
        .enter_conv (enter_conv),
        .bit_strobe (cmp_strobe),
        .bit_idx    (bit_idx),
        .done       (conv_done)
    );

    sar_adc_sar #(.RES_BITS(RES_BITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (go),
        .load_msb (enter_conv),
        .strobe   (cmp_strobe),
        .done     (conv_done),
        .bit_idx  (bit_idx),
        .cmp      (cmp_in),
        .code     (sar_code),
        .result   (result)
    );

    assign ref_sel = (ch_sel == REF_CODE);
endmodule

// File: rtl/sar_adc_seq_chk.sv
// Assertion checker for sar_adc_seq, bound to every instance of the top.
// It counts strobes per conversion and checks power, flag and channel
// relations over time.
module sar_adc_seq_chk #(
    parameter int RES_BITS = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       pwr_on,
    input logic       done_flag,
    input logic       strobe,
    input logic       done,
    input logic [3:0] ch_sel
);
    logic [5:0] stb_cnt;

    // Strobes seen in the current conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) stb_cnt <= '0;
        else if (strobe)     stb_cnt <= stb_cnt + 1'b1;
    end

    assert_strobe_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> busy);

    assert_strobe_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (strobe && stb_cnt == 6'(RES_BITS - 1)));

    assert_no_run_unpowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !busy);

    assert_flag_at_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> (!busy && $past(busy)));

    assert_chan_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch_sel));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pwr_on    (pwr_on),
    .done_flag (done_flag),
    .strobe    (cmp_strobe),
    .done      (conv_done),
    .ch_sel    (ch_sel)
);

// File: tb/sar_adc_seq_bench.sv
`timescale 1ns/1ps
module sar_adc_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        pwm_trig = 1'b0;
    logic        cmp_in;
    logic [3:0]  ch_sel;
    logic        ref_sel;
    logic [11:0] sar_code;
    logic        cmp_strobe;
    logic [11:0] vin = 12'h000;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int strobes = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sar_adc_seq u_sar_adc_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_trig(pwm_trig),
        .cmp_in(cmp_in), .ch_sel(ch_sel), .ref_sel(ref_sel),
        .sar_code(sar_code), .cmp_strobe(cmp_strobe)
    );

    // Ideal comparator: trial code at or below the input voltage.
    assign cmp_in = (sar_code <= vin);

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (cmp_strobe) strobes <= strobes + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_trig();
        @(negedge clk); pwm_trig = 1'b1;
        @(negedge clk); pwm_trig = 1'b0;
    endtask

    function automatic int conv_cycles(int spd, int sw, int hld, int smp);
        return 2 * (spd + 1) * ((sw + 1) + (hld + 1) + (smp + 1) + 12);
    endfunction

    function automatic logic [15:0] exp_word(logic [11:0] v, bit aln);
        return aln ? {4'h0, v} : {v, 4'h0};
    endfunction

    // Poll the flag from the current negedge; return elapsed edges since cs.
    task automatic wait_flag(input int cs, output int elapsed, output logic [7:0] c);
        int guard = 0;
        rd(3'd0, c);
        while (!c[5] && guard < 5000) begin
            @(negedge clk);
            guard++;
            rd(3'd0, c);
        end
        elapsed = cyc - cs;
        if (guard >= 5000) chk("R3 flag timeout", 0, 1);
    endtask

    task automatic check_result(input logic [11:0] v, input bit aln, input string req);
        logic [7:0] hi, lo;
        logic [15:0] w;
        w = exp_word(v, aln);
        rd(3'd3, hi);
        rd(3'd4, lo);
        chk(req, int'(hi), int'(w[15:8]));
        chk(req, int'(lo), int'(w[7:0]));
    endtask

    task automatic run_conv(input int spd, input int sw, input int hld, input int smp,
                            input bit aln, input int ch, input logic [11:0] v);
        logic [7:0] c;
        int cs, el, s0;
        wr(3'd1, {2'b00, aln, 1'b0, 4'(spd)});
        wr(3'd2, {1'(sw), 2'(hld), 5'(smp)});
        wr(3'd0, 8'h80);
        vin = v;
        s0 = strobes;
        wr(3'd0, {4'hC, 4'(ch)});
        cs = cyc;
        chk("R10 ch_sel", int'(ch_sel), ch);
        chk("R10 ref_sel", int'(ref_sel), (ch == 15) ? 1 : 0);
        rd(3'd0, c);
        chk("R8 start bit busy", int'(c[6]), 1);
        wait_flag(cs, el, c);
        chk("R3 conversion time", el, conv_cycles(spd, sw, hld, smp));
        chk("R8 start bit clear with flag", int'(c[6]), 0);
        repeat (2) @(negedge clk);
        chk("R4 strobe count", strobes - s0, 12);
        check_result(v, aln, aln ? "R5 R6 right result" : "R5 R6 left result");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        int cs, el, s0, dummy;
        dummy = $urandom(32'h5A17);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), c);
            chk("R1 reset reg", int'(c), 0);
        end
        chk("R1 ch_sel", int'(ch_sel), 0);
        chk("R1 ref_sel", int'(ref_sel), 0);
        chk("R1 strobe", int'(cmp_strobe), 0);
        chk("R1 sar_code", int'(sar_code), 0);

        // R2 start with power off is ignored
        s0 = strobes;
        wr(3'd0, 8'h40);
        rd(3'd0, c);
        chk("R2 unpowered start", int'(c[6]), 0);
        repeat (60) @(negedge clk);
        chk("R2 no strobes", strobes - s0, 0);

        // Directed corners
        run_conv(0, 0, 0, 9, 1'b1, 3, 12'hABC);
        run_conv(0, 0, 0, 9, 1'b0, 5, 12'hABC);
        run_conv(15, 1, 3, 31, 1'b1, 15, 12'hFFF);
        run_conv(1, 1, 2, 10, 1'b0, 0, 12'h000);

        // R7 write 1 to flag keeps it, write 0 clears it
        wr(3'd0, 8'hA0);
        rd(3'd0, c);
        chk("R7 write one keeps flag", int'(c[5]), 1);
        wr(3'd0, 8'h80);
        rd(3'd0, c);
        chk("R7 write zero clears", int'(c[5]), 0);
        wr(3'd0, 8'hA0);
        rd(3'd0, c);
        chk("R7 write one no set", int'(c[5]), 0);

        // Constrained random conversions
        for (int n = 0; n < 24; n++) begin
            run_conv($urandom % 4, $urandom % 2, $urandom % 4, 9 + ($urandom % 23),
                     1'($urandom % 2), $urandom % 16, 12'($urandom));
        end

        // R7 collision: clearing write in the completion cycle, flag already set
        wr(3'd1, 8'h20);
        wr(3'd2, 8'h09);
        vin = 12'h5A5;
        wr(3'd0, 8'hE1);
        cs = cyc;
        while (cyc - cs < conv_cycles(0, 0, 0, 9) - 1) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h81;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd0, c);
        chk("R7 set wins over clear", int'(c[5]), 1);
        chk("R8 start clear at completion", int'(c[6]), 0);
        check_result(12'h5A5, 1'b1, "R7 result with collision");

        // R11 and R2: writes during conversion change nothing in flight
        wr(3'd1, 8'h21);
        wr(3'd2, 8'h2A);
        wr(3'd0, 8'h80);
        vin = 12'h321;
        s0 = strobes;
        wr(3'd0, 8'hC2);
        cs = cyc;
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'h2F);
        wr(3'd0, 8'hC7);
        chk("R10 ch_sel frozen", int'(ch_sel), 2);
        wait_flag(cs, el, c);
        chk("R11 timing latched", el, conv_cycles(1, 0, 1, 10));
        repeat (300) @(negedge clk);
        chk("R2 start during busy ignored", strobes - s0, 12);
        wr(3'd1, 8'h20);
        check_result(12'h321, 1'b1, "R11 result");

        // R9 trigger disabled then enabled
        wr(3'd2, 8'h09);
        wr(3'd0, 8'h84);
        s0 = strobes;
        pulse_trig();
        repeat (40) @(negedge clk);
        rd(3'd0, c);
        chk("R9 trigger ignored when disabled", int'(c[6]), 0);
        chk("R9 no strobes when disabled", strobes - s0, 0);
        wr(3'd0, 8'h94);
        vin = 12'h7E1;
        @(negedge clk); pwm_trig = 1'b1;
        @(negedge clk); pwm_trig = 1'b0;
        cs = cyc;
        chk("R9 trigger channel", int'(ch_sel), 4);
        wait_flag(cs, el, c);
        chk("R9 trigger conversion time", el, conv_cycles(0, 0, 0, 9));
        check_result(12'h7E1, 1'b1, "R9 trigger result");

        // R12 abort by power off
        wr(3'd0, 8'h80);
        s0 = strobes;
        wr(3'd0, 8'hC1);
        repeat (30) @(negedge clk);
        wr(3'd0, 8'h01);
        rd(3'd0, c);
        chk("R12 start bit after abort", int'(c[6]), 0);
        s0 = strobes;
        repeat (200) @(negedge clk);
        rd(3'd0, c);
        chk("R12 no flag after abort", int'(c[5]), 0);
        chk("R12 no strobes after abort", strobes - s0, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule